// File: doc/BRIEF.md
# Frame-Synchronised Shadow Register Update Controller

This block keeps two copies of a display pipeline's configuration: a shadow set that a processor writes through a simple write strobe, and an active set that drives the scan-out logic. The active set changes only at a frame boundary, marked by a one-cycle `vsync` pulse. A transfer happens only when software has armed it by setting the update-request bit. This lets software rewrite a whole frame's worth of settings without the scan-out ever seeing a half-written mix.

The configuration is split into a global group and one group per window. The global group holds the timing words and the frame-synchronised video enable. Each window group holds a control word, whose bit 0 is the window enable, and its data words. Each window also has a protect bit. While that bit is set, the window's group is held back at the frame boundary even when an update is armed. The held transfer then completes at the first frame boundary after the protect bit is cleared. A second, immediate video enable bypasses the shadow path. A read port returns either copy, chosen by a select input.

Address map: ctrl at 0 (bit 0 immediate video enable, bit 1 frame-synchronised video enable, bit 2 update request). Protect at 1 (bit w for window w). Global words at 2 to 2+GLB_REGS-1. Window w word r at 2+GLB_REGS+w*WIN_REGS+r.

Top module: `srup_ctrl`

## Requirements
- R1: When `rst_n` is low or `soft_rst` is high at a clock edge, every shadow word, every active word, the protect bits, the update request and both video enables become zero, and all `act_win_en` bits are 0 after that edge.
- R2: A write to a global or window word changes the shadow copy, which reads back with `rd_shadow`=1 after the edge. The active copy, read with `rd_shadow`=0, is unchanged until a committing `vsync`.
- R3: At a `vsync` with the update request (ctrl bit 2) set, the global words and the frame-synchronised video enable (ctrl bit 1) are copied to the active set. The copies are visible on `act_glb` and `vid_on_frame` after that edge.
- R4: At such a `vsync`, every window whose protect bit is clear copies its whole shadow group to the active set.
- R5: A window whose protect bit (protect register bit w) is set keeps its active group at every `vsync`. Its shadow values stay pending.
- R6: A window held back by R5 transfers its pending group at the first `vsync` after its protect bit is cleared, with no new update request. It does not transfer before that `vsync`.
- R7: The update request clears itself at the `vsync` that serves it. A `vsync` with no request and no held window transfers nothing.
- R8: The immediate video enable (ctrl bit 0) drives `vid_on_now` from the edge on which it is written, with no wait for `vsync`.
- R9: Clearing a window enable (bit 0 of the window's word 0) leaves `act_win_en` at 1 until the next committing `vsync`.
- R10: Reads return the shadow copy when `rd_shadow` is 1 and the active copy otherwise. The protect register reads the same in both views. Ctrl bit 2 reads the update request in both views.
- R11: A write in the same cycle as `vsync` lands in the shadow set only and is not part of that transfer. An update request written in that cycle arms the following `vsync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| vsync | input | 1 | One-cycle frame boundary pulse |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_shadow | input | 1 | 1 selects the shadow copy for reads |
| rd_data | output | DATA_W | Read data (combinational) |
| act_glb | output | GLB_REGS*DATA_W | Active global words, word 0 lowest |
| act_win_cfg | output | NUM_WIN*WIN_REGS*DATA_W | Active window words, window-major |
| act_win_en | output | NUM_WIN | Active window enables |
| vid_on_now | output | 1 | Immediate video enable |
| vid_on_frame | output | 1 | Frame-synchronised video enable |

## Verification
The assertions assume that `vsync` is the only event allowed to move the active set, apart from a reset. They also assume that each write is one strobe carrying one full word. The stimulus drives `vsync` as an isolated one-cycle pulse and gives every write its own cycle. It raises a write and `vsync` together only on purpose, in the R11 cases. Protect bits change only through ordinary writes, so each check of a held window has a known frame boundary to count from.

// File: rtl/srup_pkg.sv
// Shared address map, control bit positions and address classifier for the
// shadow register update controller. Assumes word addressing.
package srup_pkg;

    localparam int unsigned CTRL_ADDR = 0;
    localparam int unsigned PROT_ADDR = 1;
    localparam int unsigned GLB_BASE  = 2;

    localparam int CB_NOW = 0;  // immediate video enable
    localparam int CB_FRM = 1;  // frame-synchronised video enable
    localparam int CB_UPD = 2;  // update request
    localparam int WB_EN  = 0;  // window enable, bit of window word 0

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_PROT,
        SEL_GLB,
        SEL_WIN
    } sel_e;

    // Classify a word address into the register group it belongs to.
    function automatic sel_e classify(input int unsigned a,
                                      input int unsigned nglb,
                                      input int unsigned nwin,
                                      input int unsigned wregs);
        sel_e s;
        if (a == CTRL_ADDR)
            s = SEL_CTRL;
        else if (a == PROT_ADDR)
            s = SEL_PROT;
        else if (a >= GLB_BASE && a < GLB_BASE + nglb)
            s = SEL_GLB;
        else if (a >= GLB_BASE + nglb && a < GLB_BASE + nglb + nwin * wregs)
            s = SEL_WIN;
        else
            s = SEL_NONE;
        return s;
    endfunction

endpackage

// File: rtl/srup_shadow_bank.sv
// Shadow/active pair for one register group. Writes land in the shadow
// words; a commit pulse copies every shadow word to its active word in one
// edge. Assumes at most one write per cycle and word-wide writes.
module srup_shadow_bank #(
    parameter int WORDS = 4,
    parameter int WIDTH = 32,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   soft_rst,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [WIDTH-1:0]       wr_data,
    input  logic                   commit,
    output logic [WORDS*WIDTH-1:0] shadow_q,
    output logic [WORDS*WIDTH-1:0] active_q
);

    genvar i;
    generate
        for (i = 0; i < WORDS; i++) begin : g_word
            // Shadow word: take bus writes aimed at this index.
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst)
                    shadow_q[i*WIDTH +: WIDTH] <= '0;
                else if (wr_en && wr_idx == IDX_W'(i))
                    shadow_q[i*WIDTH +: WIDTH] <= wr_data;
            end

            // Active word: copy the shadow value on a commit.
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst)
                    active_q[i*WIDTH +: WIDTH] <= '0;
                else if (commit)
                    active_q[i*WIDTH +: WIDTH] <= shadow_q[i*WIDTH +: WIDTH];
            end
        end
    endgenerate

endmodule

// File: rtl/srup_commit_ctrl.sv
// Decides at each frame boundary which groups commit. The global group
// commits when an update is armed; a window commits when an update is armed
// or a transfer of its own was held, and only if its protect bit is clear.
// Assumes vsync is a single-cycle pulse.
module srup_commit_ctrl #(
    parameter int NUM_WIN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               vsync,
    input  logic               upd_set,
    input  logic [NUM_WIN-1:0] protect,
    output logic               upd_armed,
    output logic               commit_glb,
    output logic [NUM_WIN-1:0] commit_win
);

    logic [NUM_WIN-1:0] held_q;

    assign commit_glb = vsync && upd_armed;

    // Update request: a new request wins over the clear at a served vsync.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            upd_armed <= 1'b0;
        else if (upd_set)
            upd_armed <= 1'b1;
        else if (vsync)
            upd_armed <= 1'b0;
    end

    genvar w;
    generate
        for (w = 0; w < NUM_WIN; w++) begin : g_win
            logic want;
            assign want          = upd_armed || held_q[w];
            assign commit_win[w] = vsync && want && !protect[w];

            // Held flag: remember a transfer that a protect bit blocked.
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst)
                    held_q[w] <= 1'b0;
                else if (vsync && want)
                    held_q[w] <= protect[w];
            end
        end
    endgenerate

endmodule

// File: rtl/srup_read_mux.sv
// Read-back multiplexer. Picks the shadow or active copy of the addressed
// word; control and protect registers are assembled from their bits.
// Unmapped addresses read as zero. Assumes NUM_WIN <= DATA_W and DATA_W >= 3.
module srup_read_mux
    import srup_pkg::*;
#(
    parameter int NUM_WIN  = 2,
    parameter int WIN_REGS = 4,
    parameter int GLB_REGS = 2,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    localparam int WIN_BITS = NUM_WIN * WIN_REGS * DATA_W,
    localparam int GLB_BITS = GLB_REGS * DATA_W
) (
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                rd_shadow,
    input  logic                vid_now,
    input  logic                frm_sh,
    input  logic                frm_act,
    input  logic                upd_armed,
    input  logic [NUM_WIN-1:0]  protect,
    input  logic [GLB_BITS-1:0] glb_sh,
    input  logic [GLB_BITS-1:0] glb_act,
    input  logic [WIN_BITS-1:0] win_sh,
    input  logic [WIN_BITS-1:0] win_act,
    output logic [DATA_W-1:0]   rd_data
);

    localparam int WIN_BASE = GLB_BASE + GLB_REGS;

    sel_e        sel;
    int unsigned a;
    int unsigned goff;
    int unsigned woff;

    assign a    = 32'(rd_addr);
    assign sel  = classify(a, GLB_REGS, NUM_WIN, WIN_REGS);
    assign goff = a - GLB_BASE;
    assign woff = a - WIN_BASE;

    // Select the word for the addressed group and view.
    always_comb begin
        rd_data = '0;
        unique case (sel)
            SEL_CTRL: begin
                rd_data[CB_NOW] = vid_now;
                rd_data[CB_FRM] = rd_shadow ? frm_sh : frm_act;
                rd_data[CB_UPD] = upd_armed;
            end
            SEL_PROT: rd_data[NUM_WIN-1:0] = protect;
            SEL_GLB:  rd_data = rd_shadow ? glb_sh[goff*DATA_W +: DATA_W]
                                          : glb_act[goff*DATA_W +: DATA_W];
            SEL_WIN:  rd_data = rd_shadow ? win_sh[woff*DATA_W +: DATA_W]
                                          : win_act[woff*DATA_W +: DATA_W];
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/srup_ctrl.sv
// Top of the shadow register update controller. Decodes bus writes into the
// control, protect, global and per-window groups, holds the immediate video
// enable and protect bits, and lets the commit controller move shadow groups
// to the active set at vsync. Assumes one write per cycle, word addressing.
module srup_ctrl
    import srup_pkg::*;
#(
    parameter int NUM_WIN  = 2,
    parameter int WIN_REGS = 4,
    parameter int GLB_REGS = 2,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    localparam int WIN_BITS = NUM_WIN * WIN_REGS * DATA_W,
    localparam int GLB_BITS = GLB_REGS * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst,
    input  logic                vsync,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                rd_shadow,
    output logic [DATA_W-1:0]   rd_data,
    output logic [GLB_BITS-1:0] act_glb,
    output logic [WIN_BITS-1:0] act_win_cfg,
    output logic [NUM_WIN-1:0]  act_win_en,
    output logic                vid_on_now,
    output logic                vid_on_frame
);

    localparam int WIN_BASE = GLB_BASE + GLB_REGS;
    localparam int GIDX_W   = (GLB_REGS > 1) ? $clog2(GLB_REGS) : 1;
    localparam int WIDX_W   = (WIN_REGS > 1) ? $clog2(WIN_REGS) : 1;

    sel_e               wsel;
    int unsigned        wa;
    logic               wr_ctrl;
    logic               wr_prot;
    logic               wr_glb;
    logic [GIDX_W-1:0]  glb_idx;
    logic [NUM_WIN-1:0] prot_q;
    logic               upd_armed;
    logic               commit_glb;
    logic [NUM_WIN-1:0] commit_win;
    logic [GLB_BITS-1:0] glb_sh;
    logic [WIN_BITS-1:0] win_sh;
    logic               frm_sh;
    int unsigned        goff;

    assign wa      = 32'(wr_addr);
    assign wsel    = classify(wa, GLB_REGS, NUM_WIN, WIN_REGS);
    assign wr_ctrl = wr_en && (wsel == SEL_CTRL);
    assign wr_prot = wr_en && (wsel == SEL_PROT);
    assign wr_glb  = wr_en && (wsel == SEL_GLB);
    assign goff    = wa - GLB_BASE;
    assign glb_idx = goff[GIDX_W-1:0];

    // Immediate video enable: takes the written bit at once.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            vid_on_now <= 1'b0;
        else if (wr_ctrl)
            vid_on_now <= wr_data[CB_NOW];
    end

    // Protect bits: immediate, never shadowed.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            prot_q <= '0;
        else if (wr_prot)
            prot_q <= wr_data[NUM_WIN-1:0];
    end

    srup_commit_ctrl #(
        .NUM_WIN (NUM_WIN)
    ) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .vsync      (vsync),
        .upd_set    (wr_ctrl && wr_data[CB_UPD]),
        .protect    (prot_q),
        .upd_armed  (upd_armed),
        .commit_glb (commit_glb),
        .commit_win (commit_win)
    );

    // Frame-synchronised video enable: a one-bit shadow group.
    srup_shadow_bank #(
        .WORDS (1),
        .WIDTH (1)
    ) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (wr_ctrl),
        .wr_idx   (1'b0),
        .wr_data  (wr_data[CB_FRM]),
        .commit   (commit_glb),
        .shadow_q (frm_sh),
        .active_q (vid_on_frame)
    );

    // Global timing words.
    srup_shadow_bank #(
        .WORDS (GLB_REGS),
        .WIDTH (DATA_W)
    ) u_glb (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (wr_glb),
        .wr_idx   (glb_idx),
        .wr_data  (wr_data),
        .commit   (commit_glb),
        .shadow_q (glb_sh),
        .active_q (act_glb)
    );

    genvar w;
    generate
        for (w = 0; w < NUM_WIN; w++) begin : g_win
            localparam int BASE = WIN_BASE + w * WIN_REGS;
            int unsigned       woff;
            logic              hit;
            logic [WIDX_W-1:0] widx;

            assign woff = wa - BASE;
            assign hit  = wr_en && (wsel == SEL_WIN) &&
                          (wa >= BASE) && (wa < BASE + WIN_REGS);
            assign widx = woff[WIDX_W-1:0];

            srup_shadow_bank #(
                .WORDS (WIN_REGS),
                .WIDTH (DATA_W)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .soft_rst (soft_rst),
                .wr_en    (hit),
                .wr_idx   (widx),
                .wr_data  (wr_data),
                .commit   (commit_win[w]),
                .shadow_q (win_sh[w*WIN_REGS*DATA_W +: WIN_REGS*DATA_W]),
                .active_q (act_win_cfg[w*WIN_REGS*DATA_W +: WIN_REGS*DATA_W])
            );

            assign act_win_en[w] = act_win_cfg[w*WIN_REGS*DATA_W + WB_EN];
        end
    endgenerate

    srup_read_mux #(
        .NUM_WIN  (NUM_WIN),
        .WIN_REGS (WIN_REGS),
        .GLB_REGS (GLB_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_rd (
        .rd_addr   (rd_addr),
        .rd_shadow (rd_shadow),
        .vid_now   (vid_on_now),
        .frm_sh    (frm_sh),
        .frm_act   (vid_on_frame),
        .upd_armed (upd_armed),
        .protect   (prot_q),
        .glb_sh    (glb_sh),
        .glb_act   (act_glb),
        .win_sh    (win_sh),
        .win_act   (act_win_cfg),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/srup_checker.sv
// Temporal checks on the update controller, bound to every srup_ctrl
// instance. Assumes vsync is the only commit trigger besides reset.
module srup_checker
    import srup_pkg::*;
#(
    parameter int NUM_WIN  = 2,
    parameter int WIN_REGS = 4,
    parameter int GLB_REGS = 2,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 soft_rst,
    input logic                                 vsync,
    input logic                                 wr_en,
    input logic [ADDR_W-1:0]                    wr_addr,
    input logic [DATA_W-1:0]                    wr_data,
    input logic [GLB_REGS*DATA_W-1:0]           act_glb,
    input logic [NUM_WIN*WIN_REGS*DATA_W-1:0]   act_win_cfg,
    input logic [NUM_WIN-1:0]                   act_win_en,
    input logic                                 vid_on_now,
    input logic                                 vid_on_frame,
    input logic [NUM_WIN-1:0]                   prot_q,
    input logic                                 upd_armed
);

    logic ctrl_wr;
    assign ctrl_wr = wr_en && (32'(wr_addr) == CTRL_ADDR);

    // R1: a soft reset empties the active set and the control state.
    p_soft_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (act_glb == '0 && act_win_cfg == '0 && act_win_en == '0 &&
                      !vid_on_now && !vid_on_frame && prot_q == '0 && !upd_armed));

    // R2: global active words move only at a frame boundary.
    p_glb_frame_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!vsync && !soft_rst) |=> ($stable(act_glb) && $stable(vid_on_frame)));

    // R7: a served update request is gone afterwards.
    p_upd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && upd_armed && !(ctrl_wr && wr_data[CB_UPD]) && !soft_rst)
            |=> !upd_armed);

    // R8: the immediate video enable follows the written bit.
    p_vid_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !soft_rst) |=> (vid_on_now == $past(wr_data[CB_NOW])));

    // R9: window enables change only at a frame boundary.
    p_en_frame_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!vsync && !soft_rst) |=> $stable(act_win_en));

    genvar w;
    generate
        for (w = 0; w < NUM_WIN; w++) begin : g_win
            // R5: a protected window keeps its active group.
            p_protect_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (prot_q[w] && !soft_rst) |=>
                    $stable(act_win_cfg[w*WIN_REGS*DATA_W +: WIN_REGS*DATA_W]));
        end
    endgenerate

endmodule

bind srup_ctrl srup_checker #(
    .NUM_WIN  (NUM_WIN),
    .WIN_REGS (WIN_REGS),
    .GLB_REGS (GLB_REGS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .vsync        (vsync),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .act_glb      (act_glb),
    .act_win_cfg  (act_win_cfg),
    .act_win_en   (act_win_en),
    .vid_on_now   (vid_on_now),
    .vid_on_frame (vid_on_frame),
    .prot_q       (prot_q),
    .upd_armed    (upd_armed)
);

// File: tb/tb_srup_ctrl.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, enable timing, same-cycle collisions and soft reset.
module tb_srup_ctrl;

    localparam int NUM_WIN  = 2;
    localparam int WIN_REGS = 4;
    localparam int GLB_REGS = 2;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_VS = 2'd1;
    localparam logic [1:0] OP_RS = 2'd2;
    localparam logic [1:0] OP_RA = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int N = 35;
    // Map: ctrl 0, protect 1, global 2..3, window0 4..7, window1 8..11.
    localparam vec_t TBL [N] = '{
        '{OP_WR, 8'd2, 32'hA1A1_0002, 4'd2},   // R2 shadow write
        '{OP_RS, 8'd2, 32'hA1A1_0002, 4'd2},   // R2 shadow view
        '{OP_RA, 8'd2, 32'h0000_0000, 4'd2},   // R2 active untouched
        '{OP_WR, 8'd4, 32'h0000_0001, 4'd4},
        '{OP_WR, 8'd5, 32'hB5B5_0005, 4'd4},
        '{OP_WR, 8'd8, 32'h0000_0001, 4'd4},
        '{OP_WR, 8'd9, 32'hC9C9_0009, 4'd4},
        '{OP_WR, 8'd0, 32'h0000_0006, 4'd10},  // frame enable + update
        '{OP_RS, 8'd0, 32'h0000_0006, 4'd10},  // R10 ctrl shadow view
        '{OP_RA, 8'd0, 32'h0000_0004, 4'd10},  // R10 ctrl active view
        '{OP_VS, 8'd0, 32'h0000_0000, 4'd3},
        '{OP_RA, 8'd2, 32'hA1A1_0002, 4'd3},   // R3 global committed
        '{OP_RA, 8'd0, 32'h0000_0002, 4'd7},   // R7 update self-cleared
        '{OP_RA, 8'd5, 32'hB5B5_0005, 4'd4},   // R4
        '{OP_RA, 8'd9, 32'hC9C9_0009, 4'd4},   // R4
        '{OP_WR, 8'd1, 32'h0000_0002, 4'd5},   // protect window 1
        '{OP_WR, 8'd9, 32'hD9D9_0009, 4'd5},
        '{OP_WR, 8'd5, 32'hE5E5_0005, 4'd4},
        '{OP_WR, 8'd0, 32'h0000_0006, 4'd5},
        '{OP_VS, 8'd0, 32'h0000_0000, 4'd5},
        '{OP_RA, 8'd5, 32'hE5E5_0005, 4'd4},   // R4 unprotected window moves
        '{OP_RA, 8'd9, 32'hC9C9_0009, 4'd5},   // R5 protected window held
        '{OP_RS, 8'd9, 32'hD9D9_0009, 4'd5},   // R5 pending kept
        '{OP_RA, 8'd1, 32'h0000_0002, 4'd10},  // R10 protect active view
        '{OP_RS, 8'd1, 32'h0000_0002, 4'd10},  // R10 protect shadow view
        '{OP_VS, 8'd0, 32'h0000_0000, 4'd5},
        '{OP_RA, 8'd9, 32'hC9C9_0009, 4'd5},   // R5 still held
        '{OP_WR, 8'd1, 32'h0000_0000, 4'd6},   // release
        '{OP_RA, 8'd9, 32'hC9C9_0009, 4'd6},   // R6 not before vsync
        '{OP_VS, 8'd0, 32'h0000_0000, 4'd6},
        '{OP_RA, 8'd9, 32'hD9D9_0009, 4'd6},   // R6 held transfer done
        '{OP_WR, 8'd3, 32'hF3F3_0003, 4'd7},
        '{OP_VS, 8'd0, 32'h0000_0000, 4'd7},
        '{OP_RA, 8'd3, 32'h0000_0000, 4'd7},   // R7 no request, no transfer
        '{OP_RS, 8'd3, 32'hF3F3_0003, 4'd7}    // R7 shadow still pending
    };

    logic                               clk = 1'b0;
    logic                               rst_n = 1'b0;
    logic                               soft_rst = 1'b0;
    logic                               vsync = 1'b0;
    logic                               wr_en = 1'b0;
    logic [ADDR_W-1:0]                  wr_addr = '0;
    logic [DATA_W-1:0]                  wr_data = '0;
    logic [ADDR_W-1:0]                  rd_addr = '0;
    logic                               rd_shadow = 1'b0;
    logic [DATA_W-1:0]                  rd_data;
    logic [GLB_REGS*DATA_W-1:0]         act_glb;
    logic [NUM_WIN*WIN_REGS*DATA_W-1:0] act_win_cfg;
    logic [NUM_WIN-1:0]                 act_win_en;
    logic                               vid_on_now;
    logic                               vid_on_frame;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    srup_ctrl #(
        .NUM_WIN  (NUM_WIN),
        .WIN_REGS (WIN_REGS),
        .GLB_REGS (GLB_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .vsync        (vsync),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_shadow    (rd_shadow),
        .rd_data      (rd_data),
        .act_glb      (act_glb),
        .act_win_cfg  (act_win_cfg),
        .act_win_en   (act_win_en),
        .vid_on_now   (vid_on_now),
        .vid_on_frame (vid_on_frame)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic vs();
        @(negedge clk);
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic sh, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a; rd_shadow = sh;
        #1;
        d = rd_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({30'b0, act_win_en}, 32'h0, "R1 win enables after reset");
        chk({31'b0, vid_on_now}, 32'h0, "R1 immediate video after reset");
        rd(8'd0, 1'b1, d); chk(d, 32'h0, "R1 ctrl after reset");
        rd(8'd9, 1'b1, d); chk(d, 32'h0, "R1 window shadow after reset");

        for (int i = 0; i < N; i++) begin
            case (TBL[i].op)
                OP_WR: wr(TBL[i].addr, TBL[i].data);
                OP_VS: vs();
                OP_RS: begin
                    rd(TBL[i].addr, 1'b1, d);
                    chk(d, TBL[i].data, $sformatf("R%0d table row %0d", TBL[i].req, i));
                end
                default: begin
                    rd(TBL[i].addr, 1'b0, d);
                    chk(d, TBL[i].data, $sformatf("R%0d table row %0d", TBL[i].req, i));
                end
            endcase
        end

        // R9: disabling window 0 waits for the committing vsync
        chk({30'b0, act_win_en}, 32'h3, "R9 both windows enabled");
        wr(8'd4, 32'h0);
        wr(8'd0, 32'h6);
        chk({30'b0, act_win_en}, 32'h3, "R9 enable held before vsync");
        vs();
        chk({30'b0, act_win_en}, 32'h2, "R9 window0 off after vsync");

        // R11: shadow write colliding with a committing vsync
        wr(8'd0, 32'h6);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'd2; wr_data = 32'h0000_0077; vsync = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; vsync = 1'b0;
        rd(8'd2, 1'b0, d); chk(d, 32'hA1A1_0002, "R11 colliding data not committed");
        rd(8'd2, 1'b1, d); chk(d, 32'h0000_0077, "R11 colliding data in shadow");
        rd(8'd0, 1'b0, d); chk(d, 32'h2, "R11 update served");
        // R11: update request colliding with vsync arms the next one
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'd0; wr_data = 32'h6; vsync = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; vsync = 1'b0;
        rd(8'd0, 1'b0, d); chk(d, 32'h6, "R11 update still armed");
        vs();
        rd(8'd2, 1'b0, d); chk(d, 32'h0000_0077, "R11 committed at next vsync");

        // R8: immediate video enable, frame copy unchanged
        wr(8'd0, 32'h1);
        chk({31'b0, vid_on_now}, 32'h1, "R8 immediate enable set");
        chk({31'b0, vid_on_frame}, 32'h1, "R3 frame enable waits for vsync");
        wr(8'd0, 32'h0);
        chk({31'b0, vid_on_now}, 32'h0, "R8 immediate enable cleared");

        // R1: soft reset
        wr(8'd1, 32'h1);
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk({30'b0, act_win_en}, 32'h0, "R1 soft reset enables");
        chk(act_glb[31:0], 32'h0, "R1 soft reset global active");
        chk({31'b0, vid_on_frame}, 32'h0, "R1 soft reset frame enable");
        rd(8'd5, 1'b0, d); chk(d, 32'h0, "R1 soft reset window active");
        rd(8'd5, 1'b1, d); chk(d, 32'h0, "R1 soft reset window shadow");
        rd(8'd1, 1'b0, d); chk(d, 32'h0, "R1 soft reset protect");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule